// File: doc/BRIEF.md
# Duty-Cycled Supply Drop Monitor

This block supervises a low-power supply-drop detector inside a timekeeping device. It divides its slow clock into one-second periods. At the start of each period it opens a short sampling window, and while the window is open it enables an external analog comparator. Limiting the comparator to this window keeps the average supply current small.

A select bit chooses one of two trip levels and is passed straight to the analog side. A comparator report that arrives during the window, after a short settling delay, sets a sticky low-voltage flag. While that flag is set, no further windows open. Software clears the flag through a small register port, and periodic checking then resumes. After reset the block stays quiet for an initialization hold of a whole number of seconds.

The controller is a five-state machine:
- INIT: the post-reset hold.
- IDLE: waiting for the next second boundary.
- SETTLE: comparator enabled, result ignored.
- SAMPLE: comparator enabled, result acted on.
- HOLD: flag set, sampling suspended.

Its transitions are:
- INIT→SETTLE on the last boundary of the hold.
- IDLE→SETTLE on a boundary while the flag is clear.
- SETTLE→SAMPLE after the settle cycles.
- SAMPLE→IDLE at the end of the window.
- SAMPLE→HOLD on a detected drop.
- HOLD→IDLE once the flag reads clear.

Top module: `svm_supply_monitor`

## Requirements
- R1: After reset, `low_flag_o`, `thr_sel_o` and `cmp_en_o` are 0, and a read of address 0xF returns 0x00.
- R2: `cmp_en_o` stays 0 for the first `INIT_SEC` seconds after reset. The first window opens `INIT_SEC*CYC_PER_SEC` cycles after reset is released.
- R3: While the flag is clear, `cmp_en_o` is 1 for exactly `WIN_CYC` cycles starting at each second boundary, and 0 at all other times.
- R4: A `cmp_low_i` report during the first `SETTLE_CYC` cycles of a window is ignored.
- R5: A `cmp_low_i` report in any later cycle of the window sets the flag in the next cycle. The flag is visible on `low_flag_o` and as bit 6 of the register at address 0xF.
- R6: `cmp_low_i` outside the window has no effect on the flag.
- R7: `cmp_en_o` drops in the cycle after a detection and stays 0 for as long as the flag is 1.
- R8: Writing 0 to bit 6 of address 0xF clears the flag, and writing 1 to that bit has no effect. Once the flag is cleared, windows open again from the next second boundary.
- R9: Bit 5 of address 0xF is the threshold select (0 = higher level, 1 = lower level). It is readable, `thr_sel_o` follows it, and writes to other addresses change nothing.
- R10: If a detection and a clearing write happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cmp_low_i | input | 1 | Synchronous comparator result, 1 = supply below level |
| cmp_en_o | output | 1 | Comparator enable, high only inside a window |
| thr_sel_o | output | 1 | Trip-level select to the analog side |
| low_flag_o | output | 1 | Sticky low-voltage flag |

## Verification
The hardest cases to reach are the boundaries of the comparison region inside a window: the last settle cycle, the first cycle that counts, and the final window cycle. The bench therefore sweeps a drop report across every phase from the end of settling to the last window cycle. It uses a small timing configuration, clears the flag between sweep steps, and checks that a window reopens at the following boundary. It also places a clearing write in the same cycle as a detection to check which of the two wins.

// File: rtl/svm_pkg.sv
package svm_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_HOLD
    } svm_state_t;
endpackage

// File: rtl/svm_timebase.sv
module svm_timebase #(
    parameter int CYC_PER_SEC = 32768,
    localparam int CW = $clog2(CYC_PER_SEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] phase_o,
    output logic          sec_end_o
);
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_SEC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase_o <= '0;
        else if (phase_o == LAST) phase_o <= '0;
        else                   phase_o <= phase_o + 1'b1;
    end

    assign sec_end_o = (phase_o == LAST);
endmodule

// File: rtl/svm_regs.sv
module svm_regs #(
    parameter logic [3:0] REG_ADDR = 4'hF,
    parameter int FLAG_BIT = 6,
    parameter int SEL_BIT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       set_i,
    output logic       flag_o,
    output logic       sel_o
);
    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          flag_o <= 1'b0;
        else if (set_i)                      flag_o <= 1'b1;
        else if (wr_hit && !wr_data[FLAG_BIT]) flag_o <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_o <= 1'b0;
        else if (wr_hit) sel_o <= wr_data[SEL_BIT];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_ADDR) begin
            rd_data[FLAG_BIT] = flag_o;
            rd_data[SEL_BIT]  = sel_o;
        end
    end

    AST_FLAG_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_i)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R10
endmodule

// File: rtl/svm_fsm.sv
module svm_fsm
    import svm_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768,
    parameter int WIN_CYC     = 256,
    parameter int SETTLE_CYC  = 2,
    parameter int INIT_SEC    = 1,
    localparam int CW = $clog2(CYC_PER_SEC),
    localparam int IW = $clog2(INIT_SEC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] phase_i,
    input  logic          sec_end_i,
    input  logic          cmp_low_i,
    input  logic          flag_i,
    output logic          set_o,
    output logic          cmp_en_o
);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] WIN_LAST    = CW'(WIN_CYC - 1);
    localparam logic [IW-1:0] INIT_LAST   = IW'(INIT_SEC - 1);

    svm_state_t st, st_nx;
    logic [IW-1:0] init_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_INIT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         init_cnt <= '0;
        else if (st == ST_INIT && sec_end_i) init_cnt <= init_cnt + 1'b1;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_INIT:   if (sec_end_i && init_cnt == INIT_LAST) st_nx = ST_SETTLE;
            ST_IDLE:   if (sec_end_i && !flag_i)               st_nx = ST_SETTLE;
            ST_SETTLE: if (phase_i == SETTLE_LAST)             st_nx = ST_SAMPLE;
            ST_SAMPLE: begin
                if (cmp_low_i)                 st_nx = ST_HOLD;
                else if (phase_i == WIN_LAST)  st_nx = ST_IDLE;
            end
            ST_HOLD:   if (!flag_i)                            st_nx = ST_IDLE;
            default:                                           st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmp_en_o = 1'b0;
        set_o    = 1'b0;
        unique case (st)
            ST_SETTLE: cmp_en_o = 1'b1;
            ST_SAMPLE: begin
                cmp_en_o = 1'b1;
                set_o    = cmp_low_i;
            end
            default: ;
        endcase
    end

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INIT) |-> !cmp_en_o); // R2
    AST_EN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en_o |-> (phase_i <= WIN_LAST)); // R3
    AST_OPEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_en_o) |-> (phase_i == '0)); // R3
    AST_NO_SETTLE_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> (phase_i > SETTLE_LAST)); // R4
    AST_QUIET_WHEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_i |-> !cmp_en_o); // R7
endmodule

// File: rtl/svm_supply_monitor.sv
module svm_supply_monitor #(
    parameter int CYC_PER_SEC = 32768,
    parameter int WIN_CYC     = 256,
    parameter int SETTLE_CYC  = 2,
    parameter int INIT_SEC    = 1,
    localparam int CW = $clog2(CYC_PER_SEC)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       cmp_low_i,
    output logic       cmp_en_o,
    output logic       thr_sel_o,
    output logic       low_flag_o
);
    logic [CW-1:0] phase;
    logic          sec_end;
    logic          set_flag;

    svm_timebase #(.CYC_PER_SEC(CYC_PER_SEC)) u_tb (
        .clk(clk), .rst_n(rst_n), .phase_o(phase), .sec_end_o(sec_end)
    );

    svm_fsm #(
        .CYC_PER_SEC(CYC_PER_SEC), .WIN_CYC(WIN_CYC),
        .SETTLE_CYC(SETTLE_CYC),   .INIT_SEC(INIT_SEC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .sec_end_i(sec_end),
        .cmp_low_i(cmp_low_i), .flag_i(low_flag_o), .set_o(set_flag),
        .cmp_en_o(cmp_en_o)
    );

    svm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .set_i(set_flag), .flag_o(low_flag_o), .sel_o(thr_sel_o)
    );

    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_flag_o) |-> $past(wr_en && wr_addr == 4'hF && !wr_data[6])); // R8
    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_o && !low_flag_o) |=> !low_flag_o); // R6
endmodule

// File: tb/svm_supply_monitor_tb.sv
module svm_supply_monitor_tb;
    localparam int CPS  = 64;
    localparam int WIN  = 8;
    localparam int SET  = 2;
    localparam int INIT = 1;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [3:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [3:0] rd_addr = 4'hF;
    logic [7:0] rd_data;
    logic       cmp_low = 0;
    logic       cmp_en, thr_sel, low_flag;

    int checks = 0;
    int failures = 0;
    int k = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    svm_supply_monitor #(
        .CYC_PER_SEC(CPS), .WIN_CYC(WIN), .SETTLE_CYC(SET), .INIT_SEC(INIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmp_low_i(cmp_low), .cmp_en_o(cmp_en), .thr_sel_o(thr_sel),
        .low_flag_o(low_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s k=%0d actual=%h expected=%h", req, k, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        k++;
        #1;
    endtask

    task automatic wait_phase(input int p);
        tick();
        while (k % CPS != p) tick();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        k = 0;
        // R1 reset state
        chk("R1 flag", {7'd0, low_flag}, 8'd0);
        chk("R1 thr", {7'd0, thr_sel}, 8'd0);
        chk("R1 en", {7'd0, cmp_en}, 8'd0);
        chk("R1 rd", rd_data, 8'h00);
        rd_addr = 4'h3;
        #0.1 chk("R1 rd other", rd_data, 8'h00);
        rd_addr = 4'hF;

        // R2/R3 sweep of enable over the hold and the first seconds
        for (int i = 0; i < 3 * CPS + WIN + 4; i++) begin
            tick();
            chk((k < INIT * CPS) ? "R2 en" : "R3 en", {7'd0, cmp_en},
                {7'd0, (k >= INIT * CPS) && (k % CPS < WIN)});
        end

        // R6 report outside the window
        wait_phase(WIN);
        cmp_low = 1;
        while (k % CPS != CPS - 1) tick();
        cmp_low = 0;
        chk("R6 flag", {7'd0, low_flag}, 8'd0);

        // R4 report during settle only
        tick();
        cmp_low = 1;
        repeat (SET) tick();
        cmp_low = 0;
        chk("R4 flag", {7'd0, low_flag}, 8'd0);
        chk("R3 en open", {7'd0, cmp_en}, 8'd1);

        // R5/R7/R8 sweep of detection phase
        for (int p = SET; p < WIN; p++) begin
            wait_phase(p);
            chk("R5 en before", {7'd0, cmp_en}, 8'd1);
            cmp_low = 1;
            tick();
            cmp_low = 0;
            chk("R5 flag", {7'd0, low_flag}, 8'd1);
            chk("R5 rd", rd_data, 8'h40);
            chk("R7 en drop", {7'd0, cmp_en}, 8'd0);
            wait_phase(1);
            chk("R7 no window", {7'd0, cmp_en}, 8'd0);
            wait_phase(WIN + 2);
            wr(4'hF, 8'h40);
            chk("R8 write1 ignored", {7'd0, low_flag}, 8'd1);
            wr(4'hF, 8'h00);
            chk("R8 cleared", {7'd0, low_flag}, 8'd0);
            wait_phase(0);
            chk("R8 resume", {7'd0, cmp_en}, 8'd1);
        end

        // R10 simultaneous set and clear
        wait_phase(SET + 1);
        cmp_low = 1;
        wr(4'hF, 8'h00);
        cmp_low = 0;
        chk("R10 set wins", {7'd0, low_flag}, 8'd1);
        wait_phase(WIN + 2);
        wr(4'hF, 8'h00);
        chk("R8 cleared again", {7'd0, low_flag}, 8'd0);

        // R9 threshold select
        wr(4'hF, 8'h20);
        chk("R9 thr set", {7'd0, thr_sel}, 8'd1);
        chk("R9 rd", rd_data, 8'h20);
        wr(4'h3, 8'h00);
        chk("R9 other addr", {7'd0, thr_sel}, 8'd1);
        wr(4'hF, 8'h00);
        chk("R9 thr clear", {7'd0, thr_sel}, 8'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule